// File: doc/BRIEF.md
# Status Flags and Branch Condition Evaluator

This block watches the result of an 8-bit arithmetic unit and produces four status flags from it: carry, sign, zero and overflow. When the load enable is high, the flags are captured in a 4-bit status register. Compare and test operations use the same path. They raise the load enable, but they write no destination, so their only lasting effect is on the stored flags.

A 4-bit condition code selects one branch test, which is evaluated against the stored flags. There are three groups of tests. The simple tests look at one flag each. The other two groups read the flags left by a subtraction A minus B: one interprets the operands as unsigned, the other as two's-complement signed. The subtraction is assumed to be A plus the inverted B plus one, so a set carry means no borrow occurred. The branch decision is combinational from the stored flags and the code. A flag load takes effect on the decision only after the clock edge that captures it.

Top module: `status_branch_eval`

## Requirements
- R1: On a load, the stored carry flag takes the value of the carry out of the most significant result bit.
- R2: On a load, the stored sign flag takes the value of the most significant result bit.
- R3: On a load, the stored zero flag is 1 exactly when every result bit is 0.
- R4: On a load, the stored overflow flag is the XOR of the carry into the most significant bit and the carry out of it.
- R5: While the load enable is low, the stored flags keep their values, whatever the result and carry inputs do.
- R6: Reset clears all four flags. Afterwards codes 1, 3, 5, 7, 9, 10 and 12 are taken, and codes 0, 2, 4, 6, 8, 11 and 13 are not.
- R7: The single-flag codes are: 0 taken if Z=1, 1 taken if Z=0, 2 taken if C=1, 3 taken if C=0, 4 taken if S=1, 5 taken if S=0, 6 taken if V=1, 7 taken if V=0.
- R8: After A minus B, the unsigned tests are: code 8 (higher) taken if C=1 and Z=0, code 9 (lower or same) taken if C=0 or Z=1, code 2 = higher or equal, code 3 = lower. Codes 0 and 1 give equal and not equal.
- R9: After A minus B, the signed tests are: code 10 (greater or equal) taken if S XOR V = 0, code 11 (less) taken if S XOR V = 1, code 12 (greater) taken if Z=0 and S XOR V = 0, code 13 (less or equal) taken if Z=1 or S XOR V = 1.
- R10: Code 14 is always taken and code 15 is never taken.
- R11: The taken output depends only on the stored flags and the current code. A load that happens in a cycle changes the decision only after the clock edge at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_i | input | 8 | Arithmetic unit result |
| c_msb_i | input | 1 | Carry out of the most significant bit |
| c_pre_i | input | 1 | Carry into the most significant bit (out of bit 6) |
| flag_ld_i | input | 1 | Capture the flags at the next edge |
| cond_i | input | 4 | Branch condition code |
| take_o | output | 1 | Branch taken |

## Verification
A flag load and a branch evaluation can fall in the same cycle. In that cycle the decision must come from the flags already stored, not from the result currently on the inputs. The bench provokes this by presenting a zero result with the load enable high while code 0 is selected and the stored zero flag is clear. It expects the output low before the edge and high after it. The bench also derives every expected decision from integer comparisons of the operand pairs, not from the flags, so that the unsigned and signed groups are judged against plain arithmetic.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

endpackage

// File: rtl/sbe_flag_gen.sv
module sbe_flag_gen
  import sbe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] res_i,
  input  logic          c_msb_i,
  input  logic          c_pre_i,
  output flags_t        flg_o
);

  always_comb begin
    flg_o.c = c_msb_i;
    flg_o.s = res_i[DW-1];
    flg_o.z = ~|res_i;
    flg_o.v = c_msb_i ^ c_pre_i;
  end

endmodule

// File: rtl/sbe_flag_reg.sv
module sbe_flag_reg
  import sbe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ld_i,
  input  flags_t d_i,
  output flags_t q_o
);

  flags_t q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (ld_i) begin
      q_nxt = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else begin
      q_o <= q_nxt;
    end
  end

endmodule

// File: rtl/sbe_cond_dec.sv
module sbe_cond_dec
  import sbe_pkg::*;
(
  input  flags_t     flg_i,
  input  logic [3:0] cond_i,
  output logic       take_o
);

  logic  lt_s;
  cond_e cc;

  always_comb begin
    lt_s = flg_i.s ^ flg_i.v;
    cc   = cond_e'(cond_i);
    unique case (cc)
      CC_EQ:   take_o = flg_i.z;
      CC_NE:   take_o = ~flg_i.z;
      CC_CS:   take_o = flg_i.c;
      CC_CC:   take_o = ~flg_i.c;
      CC_MI:   take_o = flg_i.s;
      CC_PL:   take_o = ~flg_i.s;
      CC_VS:   take_o = flg_i.v;
      CC_VC:   take_o = ~flg_i.v;
      CC_HI:   take_o = flg_i.c & ~flg_i.z;
      CC_LS:   take_o = ~flg_i.c | flg_i.z;
      CC_GE:   take_o = ~lt_s;
      CC_LT:   take_o = lt_s;
      CC_GT:   take_o = ~flg_i.z & ~lt_s;
      CC_LE:   take_o = flg_i.z | lt_s;
      CC_AL:   take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/status_branch_eval.sv
module status_branch_eval
  import sbe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] res_i,
  input  logic          c_msb_i,
  input  logic          c_pre_i,
  input  logic          flag_ld_i,
  input  logic [3:0]    cond_i,
  output logic          take_o
);

  flags_t flg_d;
  flags_t flg_q;

  sbe_flag_gen #(.DW(DW)) i_gen (
    .res_i   (res_i),
    .c_msb_i (c_msb_i),
    .c_pre_i (c_pre_i),
    .flg_o   (flg_d)
  );

  sbe_flag_reg i_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (flag_ld_i),
    .d_i   (flg_d),
    .q_o   (flg_q)
  );

  sbe_cond_dec i_dec (
    .flg_i  (flg_q),
    .cond_i (cond_i),
    .take_o (take_o)
  );

endmodule

// File: rtl/status_branch_eval_chk.sv
module status_branch_eval_chk
  import sbe_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] res_i,
  input logic          c_msb_i,
  input logic          c_pre_i,
  input logic          flag_ld_i,
  input logic [3:0]    cond_i,
  input logic          take_o,
  input flags_t        flg_q
);

  // R1
  carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld_i |=> flg_q.c == $past(c_msb_i));

  // R2
  sign_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld_i |=> flg_q.s == $past(res_i[DW-1]));

  // R3
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld_i |=> flg_q.z == ($past(res_i) == '0));

  // R4
  ovf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld_i |=> flg_q.v == ($past(c_msb_i) ^ $past(c_pre_i)));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_ld_i |=> $stable(flg_q));

  // R10
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'd14) |-> take_o);

  // R10
  never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'd15) |-> !take_o);

  // R11
  take_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cond_i) && !$past(flag_ld_i)) |-> $stable(take_o));

endmodule

bind status_branch_eval status_branch_eval_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_status_branch_eval.sv
`timescale 1ns/1ps
module test_status_branch_eval;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] res_i;
  logic       c_msb_i;
  logic       c_pre_i;
  logic       flag_ld_i;
  logic [3:0] cond_i;
  logic       take_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  status_branch_eval i_status_branch_eval (
    .clk(clk), .rst_n(rst_n), .res_i(res_i), .c_msb_i(c_msb_i),
    .c_pre_i(c_pre_i), .flag_ld_i(flag_ld_i), .cond_i(cond_i), .take_o(take_o)
  );

  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {8'h05, 8'h03}, {8'h03, 8'h05}, {8'h07, 8'h07}, {8'h00, 8'h00},
    {8'h80, 8'h01}, {8'h7F, 8'hFF}, {8'hFF, 8'h01}, {8'h00, 8'hFF},
    {8'h80, 8'h7F}, {8'h01, 8'h80}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: take_o=%b expected %b (cond=%0d)", req, act, exp, cond_i);
    end
  endtask

  function automatic logic expect_take(input logic [7:0] a, input logic [7:0] b,
                                       input int cc);
    int  sd;
    logic z, c, s, v;
    logic [7:0] d;
    sd = $signed(a) - $signed(b);
    d  = a - b;
    z  = (a == b);
    c  = (a >= b);
    s  = d[7];
    v  = (sd > 127) || (sd < -128);
    case (cc)
      0:  return z;
      1:  return !z;
      2:  return a >= b;
      3:  return a < b;
      4:  return s;
      5:  return !s;
      6:  return v;
      7:  return !v;
      8:  return a > b;
      9:  return a <= b;
      10: return $signed(a) >= $signed(b);
      11: return $signed(a) < $signed(b);
      12: return $signed(a) > $signed(b);
      13: return $signed(a) <= $signed(b);
      14: return 1'b1;
      default: return c & 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int cc);
    if (cc < 8)  return "R7";
    if (cc < 10) return "R8";
    if (cc < 14) return "R9";
    return "R10";
  endfunction

  task automatic load_sub(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] full;
    logic [7:0] low;
    @(negedge clk);
    full      = {1'b0, a} + {1'b0, ~b} + 9'd1;
    low       = {1'b0, a[6:0]} + {1'b0, ~b[6:0]} + 8'd1;
    res_i     = full[7:0];
    c_msb_i   = full[8];
    c_pre_i   = low[7];
    flag_ld_i = 1'b1;
    @(negedge clk);
    flag_ld_i = 1'b0;
  endtask

  task automatic load_raw(input logic [7:0] r, input logic cm, input logic cp);
    @(negedge clk);
    res_i = r; c_msb_i = cm; c_pre_i = cp; flag_ld_i = 1'b1;
    @(negedge clk);
    flag_ld_i = 1'b0;
  endtask

  task automatic probe(input int cc, input string req, input logic exp);
    cond_i = 4'(cc);
    #1;
    check(req, take_o, exp);
  endtask

  initial begin
    logic [15:0] reset_mask;
    rst_n = 1'b0; res_i = '0; c_msb_i = 1'b0; c_pre_i = 1'b0;
    flag_ld_i = 1'b0; cond_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: flags clear after reset
    reset_mask = 16'b0101_0110_1010_1010;
    for (int k = 0; k < 14; k++) probe(k, "R6", reset_mask[k]);

    // R7 R8 R9 R10: table of operand pairs, every code
    for (int i = 0; i < NV; i++) begin
      load_sub(VEC[i][15:8], VEC[i][7:0]);
      for (int k = 0; k < 16; k++)
        probe(k, req_of(k), expect_take(VEC[i][15:8], VEC[i][7:0], k));
    end

    // R1: carry out only
    load_raw(8'h01, 1'b1, 1'b1);
    probe(2, "R1", 1'b1);
    probe(6, "R1", 1'b0);
    // R2: sign from result MSB
    load_raw(8'h80, 1'b0, 1'b0);
    probe(4, "R2", 1'b1);
    probe(0, "R2", 1'b0);
    // R4: carry into MSB without carry out
    load_raw(8'h80, 1'b0, 1'b1);
    probe(6, "R4", 1'b1);
    probe(2, "R4", 1'b0);
    // R3: single nonzero bit keeps Z clear, all zero sets it
    load_raw(8'h02, 1'b0, 1'b0);
    probe(0, "R3", 1'b0);
    load_raw(8'h00, 1'b0, 1'b0);
    probe(0, "R3", 1'b1);

    // R5: inputs change with load low, flags held
    @(negedge clk);
    res_i = 8'hF1; c_msb_i = 1'b1; c_pre_i = 1'b0;
    repeat (3) @(negedge clk);
    probe(0, "R5", 1'b1);
    probe(2, "R5", 1'b0);
    probe(4, "R5", 1'b0);

    // R11: load and evaluate in the same cycle
    load_raw(8'h10, 1'b0, 1'b0);
    @(negedge clk);
    cond_i = 4'd0; res_i = 8'h00; flag_ld_i = 1'b1;
    #1;
    check("R11", take_o, 1'b0);
    @(negedge clk);
    flag_ld_i = 1'b0;
    #1;
    check("R11", take_o, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule